// File: doc/BRIEF.md
# Addressable Bit Register with Demultiplexer Mode

This block is an eight-bit storage register that is written one bit at a time. A three-bit select input picks the bit, and a single data input supplies its value. Every stored bit drives its own output, and all eight outputs can be read in parallel at all times.

Two control inputs set the mode. One blocks writes and the other clears the register. When the clear input is high and the write-block input is low, the register acts as a 1-of-8 demultiplexer. The selected output carries the data input and every other output is 0.

All updates happen on the rising clock edge, using the inputs sampled at that edge. A synchronous initialization input empties the register. Bit and select widths are parameters, and the default is eight bits.

Top module: `addr_latch8`

## Requirements
- R1: The select value is the binary index of the target bit, with sel[0] as the least significant bit. For example, sel=1 targets q[1] and sel=4 targets q[4].
- R2: When clr=0 and wr_block=0, the bit at index sel takes din at the clock edge and the other bits keep their values.
- R3: When clr=0 and wr_block=1, all bits hold their values whatever sel and din do.
- R4: When clr=1 and wr_block=1, all bits become 0 at the clock edge.
- R5: When clr=1 and wr_block=0, q becomes din at index sel and 0 at every other index.
- R6: The outputs change only at a rising clock edge. An input change between edges is not visible on q until after the next edge.
- R7: After leaving demultiplexer mode for hold mode, q keeps the last demultiplexed pattern. After leaving it for write mode, that pattern is the base for the next single-bit write.
- R8: When init=1 at a clock edge, q becomes all zeros, and init takes precedence over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous initialization, clears all bits |
| sel | input | 3 | Bit index for write or demultiplex |
| din | input | 1 | Data bit to store or route |
| wr_block | input | 1 | Blocks writes when high |
| clr | input | 1 | Clear (with wr_block high) or demultiplex (with wr_block low) |
| q | output | 8 | Parallel view of all stored bits |

## Verification
The outputs are the stored state itself, so a wrong bit shows up at q on the cycle right after the faulty edge. The corruption of an unaddressed bit during a write shows there too, as does a missed clear or a leftover bit in demultiplexer mode. A fault in hold mode would otherwise stay hidden, so the bench moves the select and data inputs while writes are blocked. Switches between demultiplexer mode and write mode check that the pattern left behind acts as the base for later writes.

// File: rtl/addr_latch8.sv
module addr_latch8 #(
  parameter int NBITS = 8,
  localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input  logic             clk,
  input  logic             init,
  input  logic [AW-1:0]    sel,
  input  logic             din,
  input  logic             wr_block,
  input  logic             clr,
  output logic [NBITS-1:0] q
);

  typedef enum logic [1:0] {
    M_WRITE = 2'b00,
    M_HOLD  = 2'b01,
    M_DEMUX = 2'b10,
    M_CLEAR = 2'b11
  } mode_e;

  mode_e            mode;
  logic [NBITS-1:0] hit;
  logic [NBITS-1:0] routed;
  logic [NBITS-1:0] nxt;

  assign mode = mode_e'({clr, wr_block});

  for (genvar i = 0; i < NBITS; i++) begin : g_dec
    assign hit[i] = (sel == AW'(i));
  end

  assign routed = hit & {NBITS{din}};

  always_comb begin
    case (mode)
      M_WRITE: nxt = (q & ~hit) | routed;
      M_HOLD:  nxt = q;
      M_DEMUX: nxt = routed;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (init) q <= '0;
    else      q <= nxt;
  end

endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int NBITS = 8,
  localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input logic             clk,
  input logic             init,
  input logic [AW-1:0]    sel,
  input logic             din,
  input logic             wr_block,
  input logic             clr,
  input logic [NBITS-1:0] q
);

  AST_INIT_ZERO: assert property (@(posedge clk) init |=> q == '0); // R8

  AST_WRITE_BIT: assert property (@(posedge clk) disable iff (init)
    (!clr && !wr_block) |=> q[$past(sel)] == $past(din)); // R2

  AST_WRITE_ONE_ONLY: assert property (@(posedge clk) disable iff (init)
    (!clr && !wr_block) |=> $countones(q ^ $past(q)) <= 1); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (init)
    (!clr && wr_block) |=> $stable(q)); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (init)
    (clr && wr_block) |=> q == '0); // R4

  AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (init)
    (clr && !wr_block) |=> $onehot0(q)); // R5

  AST_DEMUX_ROUTE: assert property (@(posedge clk) disable iff (init)
    (clr && !wr_block) |=> q[$past(sel)] == $past(din)); // R5

endmodule

bind addr_latch8 addr_latch8_chk #(.NBITS(NBITS)) u_chk (.*);

// File: tb/addr_latch8_bench.sv
module addr_latch8_bench;
  logic       clk = 1'b0;
  logic       init = 1'b1;
  logic [2:0] sel = '0;
  logic       din = 1'b0;
  logic       wr_block = 1'b0;
  logic       clr = 1'b0;
  logic [7:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model = '0;

  addr_latch8 u_addr_latch8 (.clk(clk), .init(init), .sel(sel), .din(din),
                             .wr_block(wr_block), .clr(clr), .q(q));

  always #2 clk = ~clk;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] ref_next(input logic [7:0] cur, input int a,
                                          input bit d, input bit wb, input bit c,
                                          input bit ini);
    logic [7:0] r;
    r = cur;
    if (ini) r = 8'h00;
    else if (c && wb) r = 8'h00;
    else if (c) begin
      r = 8'h00;
      r[a] = d;
    end else if (!wb) r[a] = d;
    return r;
  endfunction

  task automatic step(input int a, input bit d, input bit wb, input bit c, input string tag);
    sel = 3'(a); din = d; wr_block = wb; clr = c;
    #1;
    chk(q, model, "R6");
    @(posedge clk);
    model = ref_next(model, a, d, wb, c, init);
    @(negedge clk);
    chk(q, model, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    @(negedge clk);
    chk(q, 8'h00, "R8");
    init = 1'b0;

    step(1, 1, 0, 0, "R1");
    chk(q, 8'b0000_0010, "R1");
    step(4, 1, 0, 0, "R1");
    chk(q, 8'b0001_0010, "R1");

    for (int a = 0; a < 8; a++) step(a, a[0], 0, 0, "R2");
    for (int a = 0; a < 8; a++) step(a, 1, 0, 0, "R2");
    step(3, 0, 0, 0, "R2");
    chk(q, 8'b1111_0111, "R2");

    for (int a = 0; a < 8; a++) step(a, ~a[0], 1, 0, "R3");
    chk(q, 8'b1111_0111, "R3");

    step(5, 1, 1, 1, "R4");
    chk(q, 8'h00, "R4");

    for (int a = 0; a < 8; a++) begin
      step(a, 1, 0, 1, "R5");
      chk(q, 8'(1 << a), "R5");
    end
    step(6, 0, 0, 1, "R5");
    chk(q, 8'h00, "R5");

    step(2, 1, 0, 1, "R5");
    step(7, 0, 1, 0, "R7");
    step(0, 1, 1, 0, "R7");
    chk(q, 8'b0000_0100, "R7");
    step(6, 1, 0, 0, "R7");
    chk(q, 8'b0100_0100, "R7");
    step(1, 1, 0, 1, "R7");
    step(1, 0, 0, 0, "R7");
    chk(q, 8'h00, "R7");

    step(0, 1, 0, 0, "R2");
    step(7, 1, 0, 0, "R2");
    init = 1'b1;
    step(3, 1, 0, 0, "R8");
    chk(q, 8'h00, "R8");
    init = 1'b0;

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step($urandom_range(0, 7), 1'($urandom_range(0, 1)), r >= 5 && r < 8, r >= 8 || r == 4,
           "R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule